// File: doc/BRIEF.md
# Multiplexed Sampling Successive-Approximation Sequencer

This block drives a multichannel acquisition chain built from an analog multiplexer, a sample-and-hold stage and a successive-approximation converter. For each channel it holds the sample-and-hold in track mode for a programmable number of clock cycles, switches it to hold, and then runs a binary search. In each search step it presents a trial code to the converter's DAC and reads back one comparator bit.

The sample-and-hold freezes the input as soon as hold is asserted. On that same edge the sequencer therefore moves the multiplexer to the next channel, so the next channel settles while the current one is being converted. Each finished conversion comes out as a one-cycle valid pulse together with the code and the index of the channel it belongs to.

A scan covers channels 0 up to a configured last channel. A scan begins only while the start input is high. At the end of a scan the block either starts the next scan at once or returns to idle.

Top module: `sar_scan_seq`

## Requirements
- R1: After synchronous reset, hold_o is 0 (track mode), mux_sel_o is 0, dac_code_o is 0 and res_valid_o is 0.
- R2: In idle with start_i low, hold_o stays 0 and no result is produced.
- R3: Between two conversions of one run, hold_o is low for exactly max(acq_cycles_i, 1) cycles, so an acquisition value of 0 acts as 1.
- R4: hold_o is high for exactly NBITS consecutive cycles per conversion, whatever the input level.
- R5: The trials go MSB first. In the first hold cycle dac_code_o has only bit NBITS-1 set. In hold cycle k, bit NBITS-1-k is set as the trial bit, every bit below it is 0, and every bit above it keeps the decision already taken. A bit is kept when cmp_i is 1, where cmp_i = 1 means the DAC code does not exceed the held input.
- R6: With an ideal comparator, the result code equals the held input code, including the extreme values 0 and all-ones.
- R7: On the edge where hold_o rises, mux_sel_o moves from the channel being converted to the next channel.
- R8: The channel after last_chan_i is 0. A last_chan_i of 0 keeps channel 0 selected, and at the end of a scan mux_sel_o rests at 0.
- R9: res_valid_o is a single-cycle pulse in the cycle right after the last hold cycle. It carries res_code_o and res_chan_o, where res_chan_o is the channel that was converted.
- R10: If start_i is high when the last channel's conversion ends, a new scan follows at once. Otherwise the block goes idle and produces no further results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a scan from idle; when high at the end of a scan, continues scanning |
| acq_cycles_i | input | ACQW | Acquisition time in clock cycles (0 is treated as 1) |
| last_chan_i | input | CHW | Highest channel index of the scan |
| cmp_i | input | 1 | Comparator: 1 when the DAC code is at or below the held input |
| hold_o | output | 1 | Sample-and-hold control: 1 = hold, 0 = track |
| mux_sel_o | output | CHW | Multiplexer channel select |
| dac_code_o | output | NBITS | Trial code driven to the converter DAC |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_code_o | output | NBITS | Conversion result |
| res_chan_o | output | CHW | Channel of the result |

## Verification
The bound checker watches the following on every cycle: the length of each hold window, the MSB-only first trial, the multiplexer step on the hold edge, the position and single-cycle width of the result strobe, the range of the result channel, and the reset state.

Only the bench's scenarios can show the rest, because each needs a model of the held analog level and of the scan. That covers the exact acquisition length between conversions, the bit-by-bit trial sequence, the result values, the channel order across wraps, and whether scanning continues or stops depending on start_i.

// File: rtl/sar_scan_pkg.sv
package sar_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2
    } seq_state_t;

    // Channel that follows cur within a scan ending at last (clamped to nchan-1)
    function automatic int unsigned advance_chan(input int unsigned cur,
                                                 input int unsigned last,
                                                 input int unsigned nchan);
        int unsigned top;
        top = (last > nchan - 1) ? nchan - 1 : last;
        return (cur >= top) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int ACQW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [ACQW-1:0] load_val,
    input  logic            en,
    output logic            expire
);
    logic [ACQW-1:0] cnt_q;

    assign expire = (cnt_q == ACQW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ACQW'(1);
        end else if (load) begin
            cnt_q <= (load_val == '0) ? ACQW'(1) : load_val;
        end else if (en && !expire) begin
            cnt_q <= cnt_q - ACQW'(1);
        end
    end
endmodule

// File: rtl/sar_bit_search.sv
module sar_bit_search #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             step,
    input  logic             cmp,
    output logic [NBITS-1:0] trial,
    output logic [NBITS-1:0] decided,
    output logic             last_bit
);
    localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [NBITS-1:0] MSB_ONLY = NBITS'(1) << (NBITS - 1);

    logic [NBITS-1:0] trial_q;
    logic [IDXW-1:0]  idx_q;
    logic [NBITS-1:0] cur_bit;

    assign cur_bit  = NBITS'(1) << idx_q;
    assign decided  = cmp ? trial_q : (trial_q & ~cur_bit);
    assign last_bit = (idx_q == '0);
    assign trial    = trial_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q <= '0;
            idx_q   <= '0;
        end else if (init) begin
            trial_q <= MSB_ONLY;
            idx_q   <= IDXW'(NBITS - 1);
        end else if (step) begin
            trial_q <= last_bit ? decided : (decided | (cur_bit >> 1));
            if (!last_bit) idx_q <= idx_q - IDXW'(1);
        end
    end
endmodule

// File: rtl/sar_chan_ptr.sv
module sar_chan_ptr #(
    parameter int NCHAN = 4,
    localparam int CHW = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           advance,
    input  logic [CHW-1:0] last,
    output logic [CHW-1:0] sel
);
    import sar_scan_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (advance) begin
            sel <= CHW'(advance_chan(int'(sel), int'(last), NCHAN));
        end
    end
endmodule

// File: rtl/sar_scan_seq.sv
module sar_scan_seq #(
    parameter int NBITS = 8,
    parameter int NCHAN = 4,
    parameter int ACQW  = 8,
    localparam int CHW = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [ACQW-1:0]  acq_cycles_i,
    input  logic [CHW-1:0]   last_chan_i,
    input  logic             cmp_i,
    output logic             hold_o,
    output logic [CHW-1:0]   mux_sel_o,
    output logic [NBITS-1:0] dac_code_o,
    output logic             res_valid_o,
    output logic [NBITS-1:0] res_code_o,
    output logic [CHW-1:0]   res_chan_o
);
    import sar_scan_pkg::*;

    seq_state_t       state_q;
    logic [CHW-1:0]   conv_chan_q;
    logic             acq_done;
    logic             srch_last;
    logic [NBITS-1:0] srch_code;
    logic             scan_end;
    logic             go_idle;
    logic             timer_load;
    logic             acq_exit;

    assign acq_exit   = (state_q == ST_ACQ) && acq_done;
    assign scan_end   = (conv_chan_q >= last_chan_i) || (conv_chan_q == CHW'(NCHAN - 1));
    assign go_idle    = scan_end && !start_i;
    assign timer_load = ((state_q == ST_IDLE) && start_i) ||
                        ((state_q == ST_CONV) && srch_last && !go_idle);

    sar_acq_timer #(.ACQW(ACQW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (acq_cycles_i),
        .en       (state_q == ST_ACQ),
        .expire   (acq_done)
    );

    sar_bit_search #(.NBITS(NBITS)) u_search (
        .clk      (clk),
        .rst      (rst),
        .init     (acq_exit),
        .step     (state_q == ST_CONV),
        .cmp      (cmp_i),
        .trial    (dac_code_o),
        .decided  (srch_code),
        .last_bit (srch_last)
    );

    sar_chan_ptr #(.NCHAN(NCHAN)) u_chan (
        .clk     (clk),
        .rst     (rst),
        .advance (acq_exit),
        .last    (last_chan_i),
        .sel     (mux_sel_o)
    );

    assign hold_o = (state_q == ST_CONV);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            conv_chan_q <= '0;
            res_valid_o <= 1'b0;
            res_code_o  <= '0;
            res_chan_o  <= '0;
        end else begin
            res_valid_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) state_q <= ST_ACQ;
                ST_ACQ: begin
                    if (acq_done) begin
                        state_q     <= ST_CONV;
                        conv_chan_q <= mux_sel_o;
                    end
                end
                ST_CONV: begin
                    if (srch_last) begin
                        res_valid_o <= 1'b1;
                        res_code_o  <= srch_code;
                        res_chan_o  <= conv_chan_q;
                        state_q     <= go_idle ? ST_IDLE : ST_ACQ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_scan_chk.sv
module sar_scan_chk #(
    parameter int NBITS = 8,
    parameter int NCHAN = 4,
    localparam int CHW  = (NCHAN > 1) ? $clog2(NCHAN) : 1,
    localparam int RUNW = $clog2(NBITS + 1) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             hold_o,
    input logic [CHW-1:0]   mux_sel_o,
    input logic [CHW-1:0]   last_chan_i,
    input logic [NBITS-1:0] dac_code_o,
    input logic             res_valid_o,
    input logic [CHW-1:0]   res_chan_o
);
    import sar_scan_pkg::*;

    localparam logic [NBITS-1:0] MSB_ONLY = NBITS'(1) << (NBITS - 1);

    logic [RUNW-1:0] hold_run;

    always_ff @(posedge clk) begin
        if (rst)          hold_run <= '0;
        else if (hold_o)  hold_run <= hold_run + RUNW'(1);
        else              hold_run <= '0;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!hold_o && mux_sel_o == '0 && !res_valid_o));

    p_hold_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> hold_run == RUNW'(NBITS));

    p_first_trial_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_o) |-> dac_code_o == MSB_ONLY);

    p_mux_step_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_o) |-> mux_sel_o ==
            CHW'(advance_chan(int'($past(mux_sel_o)), int'($past(last_chan_i)), NCHAN)));

    p_chan_range_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> res_chan_o <= last_chan_i);

    p_valid_at_end_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $fell(hold_o));

    p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);
endmodule

bind sar_scan_seq sar_scan_chk #(.NBITS(NBITS), .NCHAN(NCHAN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hold_o      (hold_o),
    .mux_sel_o   (mux_sel_o),
    .last_chan_i (last_chan_i),
    .dac_code_o  (dac_code_o),
    .res_valid_o (res_valid_o),
    .res_chan_o  (res_chan_o)
);

// File: tb/sar_scan_seq_tb.sv
module sar_scan_seq_tb;
    localparam int NBITS = 8;
    localparam int NCHAN = 4;
    localparam int ACQW  = 8;
    localparam int CHW   = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [ACQW-1:0]  acq_cycles_i = '0;
    logic [CHW-1:0]   last_chan_i = '0;
    logic             cmp_i;
    logic             hold_o;
    logic [CHW-1:0]   mux_sel_o;
    logic [NBITS-1:0] dac_code_o;
    logic             res_valid_o;
    logic [NBITS-1:0] res_code_o;
    logic [CHW-1:0]   res_chan_o;

    always #2 clk = ~clk;   // 250 MHz

    sar_scan_seq #(.NBITS(NBITS), .NCHAN(NCHAN), .ACQW(ACQW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .acq_cycles_i(acq_cycles_i),
        .last_chan_i(last_chan_i), .cmp_i(cmp_i), .hold_o(hold_o),
        .mux_sel_o(mux_sel_o), .dac_code_o(dac_code_o), .res_valid_o(res_valid_o),
        .res_code_o(res_code_o), .res_chan_o(res_chan_o)
    );

    logic [NBITS-1:0] vin [NCHAN];
    logic [NBITS-1:0] held = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int nres     = 0;
    int exp_ch   = 0;
    int last_exp = 0;
    int acq_exp  = 1;
    int holds_in_scan = 0;
    int low_run  = 0;
    int high_run = 0;
    logic hold_prev = 1'b0;
    int cyc = 0;
    bit finished = 0;

    // Ideal comparator on the held level: 1 when DAC code <= held input
    assign cmp_i = (dac_code_o <= held);

    always @(negedge clk) if (!hold_o) held <= vin[mux_sel_o];

    function automatic int next_ch(input int cur, input int last);
        return (cur >= last) ? 0 : cur + 1;
    endfunction

    function automatic int trial_exp(input int v, input int k);
        int upper_mask;
        upper_mask = ((1 << NBITS) - 1) & ~((1 << (NBITS - k)) - 1);
        return (v & upper_mask) | (1 << (NBITS - 1 - k));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (hold_o) begin
                if (!hold_prev) begin
                    if (holds_in_scan > 0)
                        chk(low_run == acq_exp, "R3 acquisition length", low_run, acq_exp);
                    chk(int'(mux_sel_o) == next_ch(exp_ch, last_exp), "R7 R8 mux advance",
                        int'(mux_sel_o), next_ch(exp_ch, last_exp));
                    holds_in_scan++;
                    high_run = 0;
                end
                if (high_run < NBITS)
                    chk(int'(dac_code_o) == trial_exp(int'(vin[exp_ch]), high_run),
                        "R5 trial code", int'(dac_code_o), trial_exp(int'(vin[exp_ch]), high_run));
                high_run++;
                low_run = 0;
            end else begin
                if (hold_prev)
                    chk(high_run == NBITS, "R4 hold length", high_run, NBITS);
                low_run++;
            end
            if (res_valid_o) begin
                chk(!hold_o && hold_prev, "R9 strobe timing", int'(hold_o), 0);
                chk(res_code_o == vin[exp_ch], "R6 result code", int'(res_code_o), int'(vin[exp_ch]));
                chk(int'(res_chan_o) == exp_ch, "R9 result channel", int'(res_chan_o), exp_ch);
                exp_ch = next_ch(exp_ch, last_exp);
                nres++;
            end
        end
        hold_prev = hold_o;
        if (cyc > 150000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic run_scan(input int last, input int acq, input int nscans, input int vmode);
        int base;
        int guard;
        @(negedge clk); #1;
        last_chan_i  = CHW'(last);
        acq_cycles_i = ACQW'(acq);
        for (int c = 0; c < NCHAN; c++) begin
            case (vmode)
                1:       vin[c] = '0;
                2:       vin[c] = '1;
                3:       vin[c] = (c % 2 == 0) ? '1 : '0;
                default: vin[c] = NBITS'($urandom);
            endcase
        end
        last_exp = last;
        acq_exp  = (acq == 0) ? 1 : acq;
        exp_ch   = 0;
        holds_in_scan = 0;
        base  = nres;
        start_i = 1'b1;
        guard = 0;
        if (nscans == 1) begin
            @(negedge clk); #1;
        end else begin
            while (nres < base + (nscans - 1) * (last + 1) && guard < 20000) begin
                @(negedge clk); #1; guard++;
            end
        end
        start_i = 1'b0;
        while (nres < base + nscans * (last + 1) && guard < 20000) begin
            @(negedge clk); #1; guard++;
        end
        chk(nres == base + nscans * (last + 1), "R10 result count", nres - base, nscans * (last + 1));
        repeat (acq_exp + NBITS + 6) @(negedge clk);
        #1;
        chk(nres == base + nscans * (last + 1), "R10 no result after scan end", nres - base,
            nscans * (last + 1));
        chk(hold_o == 1'b0, "R2 idle in track mode", int'(hold_o), 0);
        chk(mux_sel_o == '0, "R8 mux rests at 0", int'(mux_sel_o), 0);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        for (int c = 0; c < NCHAN; c++) vin[c] = '0;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(hold_o == 1'b0, "R1 reset hold", int'(hold_o), 0);
        chk(mux_sel_o == '0, "R1 reset mux", int'(mux_sel_o), 0);
        chk(dac_code_o == '0, "R1 reset dac", int'(dac_code_o), 0);
        chk(res_valid_o == 1'b0, "R1 reset valid", int'(res_valid_o), 0);
        repeat (10) @(negedge clk);
        chk(hold_o == 1'b0 && nres == 0, "R2 idle without start", nres, 0);

        run_scan(3, 5, 1, 0);      // full scan, random levels
        run_scan(3, 0, 1, 1);      // acquisition 0 acts as 1, all-zero input
        run_scan(3, 1, 1, 2);      // all-ones input
        run_scan(0, 3, 2, 3);      // single channel, back-to-back scans
        run_scan(2, 4, 2, 0);      // continuing scan wraps after channel 2
        run_scan(1, 255, 1, 3);    // longest acquisition
        for (int i = 0; i < 8; i++)
            run_scan(int'($urandom % NCHAN), int'($urandom % 12), 1 + int'($urandom % 2), 0);

        finish_run();
    end
endmodule